// File: doc/BRIEF.md
# Gate-Triggered Programmable Clock Divider

This block turns a free-running reference clock into a divided output clock whose phase is restarted by an external, asynchronous gate. When the gate rises, the output starts on a known reference edge. It then runs at the reference frequency divided by (D+1), where D is an 8-bit divisor. When the gate falls, the output is forced low and stays low until the next accepted gate rise. Restarts are aligned to reference clock edges; no sub-cycle phase adjustment is made.

The gate passes through a synchronizer, a rising-edge detector and a low-time qualifier. A gate rise is accepted only if the gate has been low for at least `MIN_LOW` reference cycles. The divisor is captured at the accepted rise and held for the whole burst. With D above zero, the output is a registered level produced by a restartable counter. With D equal to zero, the reference itself is passed out through a latch-based glitch-free gating cell.

A state machine controls the sequence. It has five states:
- `S_IDLE`: output low, waiting for a gate rise.
- `S_BLOCKED`: the gate rose too soon; output held low until the gate drops.
- `S_HIGH`: high part of a divided period.
- `S_LOW`: low part of a divided period.
- `S_PASS`: reference passed straight through.

Its transitions are:
- IDLE→PASS: accepted rise with D=0.
- IDLE→HIGH: accepted rise with D>0.
- IDLE→BLOCKED: rise after too short a low time.
- HIGH→LOW: end of the high count.
- LOW→HIGH: counter wrap at D.
- HIGH, LOW, PASS or BLOCKED→IDLE: synchronized gate low.

Top module: `gated_divider`

## Requirements
- R1: With D in 1..255, the output is periodic with a period of exactly D+1 reference cycles for as long as the gate stays high; no period is stretched or shortened.
- R2: Within each divided period, the output is high for floor((D+1)/2) reference cycles, starting at the counter restart, and low for the remaining cycles.
- R3: With D=0, the output carries the reference clock through a latch-based gate. It is high during the high phase of every reference cycle from the 4th cycle after the gate rise through the 3rd cycle after the gate fall. It is low in every low phase and at all other times.
- R4: A gate rise placed just before reference edge n is followed by a divided output that goes high in the cycle after edge n+2. This is the first cycle of a fresh period, so each accepted rise restarts the phase.
- R5: A gate fall placed just before reference edge m forces the divided output low from edge m+2 onward. The output then stays low until the next accepted rise.
- R6: The divisor is sampled at the accepted gate rise. Any change of the divisor input during a burst has no effect on the output until the next accepted rise.
- R7: A gate rise is accepted only if the synchronized gate was low for at least MIN_LOW reference cycles (default 4) immediately before it. After a shorter low pulse, the output stays low for the whole following high period.
- R8: A synchronous active-high reset forces the output low and clears the low-time count. A gate that is already high when reset ends therefore produces no output until it has gone low for MIN_LOW cycles and risen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_in | input | 1 | Asynchronous gate; a rising edge restarts the output, a low level silences it |
| div_in | input | DIV_W (8) | Divisor D; output frequency is reference/(D+1) |
| clk_out | output | 1 | Gated, divided output clock |

## Verification
Each gate rise the bench places just before reference edge n shows up at the output two edges later, in the cycle after edge n+2: the rise crosses two synchronizer flops, and the state and output level registers load on the following edge. A gate fall reaches the output with the same two-edge delay. In pass-through mode, the gating latch holds one extra high phase after the fall. When the driver places a gate edge, it converts it into a per-cycle list of expected high-phase and low-phase levels, indexed by reference cycle and built from these latencies and the (D+1) period model. The monitor samples the output a quarter period into each phase of every cycle and compares both phase levels whenever it reaches a listed cycle.

// File: rtl/gdiv_pkg.sv
package gdiv_pkg;
    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_BLOCKED = 3'd1,
        S_HIGH    = 3'd2,
        S_LOW     = 3'd3,
        S_PASS    = 3'd4
    } gdiv_state_t;
endpackage

// File: rtl/gdiv_gate_sync.sv
module gdiv_gate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic gate_in,
    output logic gate_s,
    output logic gate_rise
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;
    logic          gate_d;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= gate_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[LAST-1:0], gate_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) gate_d <= 1'b0;
        else     gate_d <= chain[LAST];
    end

    assign gate_s    = chain[LAST];
    assign gate_rise = chain[LAST] & ~gate_d;
endmodule

// File: rtl/gdiv_gap_qual.sv
module gdiv_gap_qual #(
    parameter int MIN_LOW = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic gate_s,
    output logic qualified
);
    localparam int LW = $clog2(MIN_LOW + 1);
    localparam logic [LW-1:0] LIMIT = LW'(MIN_LOW);

    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
        end else if (gate_s) begin
            low_cnt <= '0;
        end else if (low_cnt != LIMIT) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign qualified = (low_cnt == LIMIT);

    // R7: the low-time count saturates at the limit and never passes it
    assert_low_cnt_sat_R7: assert property (@(posedge clk) disable iff (rst)
        low_cnt <= LIMIT);

    // R7: a high synchronized gate empties the count on the next edge
    assert_low_cnt_clear_R7: assert property (@(posedge clk) disable iff (rst)
        gate_s |=> (low_cnt == '0));
endmodule

// File: rtl/gdiv_counter.sv
module gdiv_counter #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    input  logic             run,
    output logic             half_end,
    output logic             wrap
);
    localparam int HW = DIV_W + 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt;
    logic [HW-1:0]    half_len;

    always_ff @(posedge clk) begin
        if (rst)       div_q <= '0;
        else if (load) div_q <= div_in;
    end

    assign half_len = ({1'b0, div_q} + HW'(1)) >> 1;
    assign half_end = ({1'b0, cnt} == (half_len - HW'(1)));
    assign wrap     = (cnt == div_q);

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (load)      cnt <= '0;
        else if (!run)      cnt <= '0;
        else if (wrap)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    // R6: the held divisor only changes on a load
    assert_div_held_R6: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(div_q));

    // R1: the running count stays inside one period
    assert_cnt_bounded_R1: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= div_q));
endmodule

// File: rtl/gdiv_clk_gate.sv
module gdiv_clk_gate (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    logic en_lat;

    always_latch begin
        if (!clk) en_lat <= en;
    end

    assign gclk = clk & en_lat;
endmodule

// File: rtl/gated_divider.sv
module gated_divider
    import gdiv_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int MIN_LOW     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate_in,
    input  logic [DIV_W-1:0] div_in,
    output logic             clk_out
);
    gdiv_state_t state, state_nxt;

    logic gate_s, gate_rise, qualified;
    logic half_end, wrap;
    logic accept, run;
    logic level_q, pass_en_q, gclk;

    gdiv_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .gate_in   (gate_in),
        .gate_s    (gate_s),
        .gate_rise (gate_rise)
    );

    gdiv_gap_qual #(.MIN_LOW(MIN_LOW)) u_gap (
        .clk       (clk),
        .rst       (rst),
        .gate_s    (gate_s),
        .qualified (qualified)
    );

    assign accept = (state == S_IDLE) && gate_rise && qualified;
    assign run    = (state == S_HIGH) || (state == S_LOW);

    gdiv_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .div_in   (div_in),
        .run      (run),
        .half_end (half_end),
        .wrap     (wrap)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= state_nxt;
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: begin
                if (gate_rise) begin
                    if (!qualified)          state_nxt = S_BLOCKED;
                    else if (div_in == '0)   state_nxt = S_PASS;
                    else                     state_nxt = S_HIGH;
                end
            end
            S_BLOCKED: begin
                if (!gate_s) state_nxt = S_IDLE;
            end
            S_HIGH: begin
                if (!gate_s)       state_nxt = S_IDLE;
                else if (half_end) state_nxt = S_LOW;
            end
            S_LOW: begin
                if (!gate_s)   state_nxt = S_IDLE;
                else if (wrap) state_nxt = S_HIGH;
            end
            S_PASS: begin
                if (!gate_s) state_nxt = S_IDLE;
            end
            default: state_nxt = S_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            level_q   <= 1'b0;
            pass_en_q <= 1'b0;
        end else begin
            level_q   <= (state_nxt == S_HIGH);
            pass_en_q <= (state_nxt == S_PASS);
        end
    end

    gdiv_clk_gate u_cg (
        .clk  (clk),
        .en   (pass_en_q),
        .gclk (gclk)
    );

    assign clk_out = gclk | level_q;

    // R5: a low synchronized gate silences both output paths on the next edge
    assert_low_forces_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !gate_s |=> (!level_q && !pass_en_q));

    // R4: a divided high phase can only begin while the gate was seen high
    assert_start_needs_gate_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(level_q) |-> $past(gate_s));

    // R7: an unqualified rise never starts the output
    assert_short_gap_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        ((state == S_IDLE) && gate_rise && !qualified) |=> (!level_q && !pass_en_q));

    // R3: pass-through and divided level are never active together
    assert_modes_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(level_q && pass_en_q));
endmodule

// File: tb/tb_gated_divider.sv
module tb_gated_divider;
    localparam int CLK_T   = 10;
    localparam int DIV_W   = 8;
    localparam int MIN_LOW = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             gate_in = 1'b1;
    logic [DIV_W-1:0] div_in = '0;
    logic             clk_out;

    gated_divider #(.DIV_W(DIV_W), .MIN_LOW(MIN_LOW)) dut (
        .clk     (clk),
        .rst     (rst),
        .gate_in (gate_in),
        .div_in  (div_in),
        .clk_out (clk_out)
    );

    always #(CLK_T/2) clk = ~clk;

    typedef struct {
        int    cyc;
        bit    hi;
        bit    lo;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    int   prev_low = 0;
    bit   done = 1'b0;

    // monitor: samples both phases of every cycle, compares listed cycles
    always @(posedge clk) begin
        bit h, l;
        exp_t it;
        cyc = cyc + 1;
        #(CLK_T/4);
        h = clk_out;
        #(CLK_T/2);
        l = clk_out;
        if (q.size() > 0 && q[0].cyc == cyc) begin
            it = q.pop_front();
            n_cmp++;
            if (h !== it.hi || l !== it.lo) begin
                n_bad++;
                $display("FAIL %s cycle %0d: actual hi=%0b lo=%0b expected hi=%0b lo=%0b",
                         it.tag, cyc, h, l, it.hi, it.lo);
            end
        end
    end

    task automatic push(input int c, input bit hi, input bit lo, input string tag);
        exp_t e;
        e.cyc = c; e.hi = hi; e.lo = lo; e.tag = tag;
        q.push_back(e);
    endtask

    // driver: one gate burst of H high cycles then L low cycles
    task automatic burst(input int d, input int h, input int l,
                         input string tag, input bit chg);
        int  c0;
        bit  ok;
        ok = (prev_low >= MIN_LOW);
        @(negedge clk);
        div_in  = DIV_W'(d);
        gate_in = 1'b1;
        c0 = cyc;
        for (int c = c0 + 1; c <= c0 + h + l; c++) begin
            bit    hi, lo;
            int    k;
            string t;
            k  = c - (c0 + 3);
            hi = 1'b0; lo = 1'b0;
            t  = tag;
            if (c == c0 + 3)     t = "R4";
            if (c >= c0 + h + 3) t = "R5";
            if (ok && d > 0 && k >= 0 && k < h) begin
                hi = ((k % (d + 1)) < ((d + 1) / 2));
                lo = hi;
            end
            if (ok && d == 0 && c >= c0 + 4 && c <= c0 + h + 3) hi = 1'b1;
            push(c, hi, lo, t);
        end
        for (int i = 0; i < h; i++) begin
            @(negedge clk);
            if (chg && i == 4) div_in = DIV_W'(d + 9); // R6: mid-burst change
        end
        gate_in = 1'b0;
        for (int i = 1; i < l; i++) @(negedge clk);
        prev_low = l;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R8: output low during reset
        n_cmp++;
        if (clk_out !== 1'b0) begin
            n_bad++;
            $display("FAIL R8 in reset: actual=%0b expected=0", clk_out);
        end
        rst = 1'b0;
        // R8: gate already high after reset gives no output
        for (int c = cyc + 1; c <= cyc + 12; c++) push(c, 1'b0, 1'b0, "R8");
        repeat (12) @(negedge clk);
        gate_in = 1'b0;
        repeat (9) @(negedge clk);
        prev_low = 10;

        burst(1,   20,  6, "R1", 1'b0);
        burst(2,   30,  4, "R2", 1'b0);
        burst(4,   33,  5, "R2", 1'b0);
        burst(0,   15,  4, "R3", 1'b0);
        burst(255, 600, 8, "R1", 1'b0);
        burst(6,   40,  3, "R6", 1'b1);
        burst(3,   20,  6, "R7", 1'b0);
        burst(3,   25,  6, "R4", 1'b0);
        burst(0,   2,   5, "R3", 1'b0);
        burst(5,   4,   4, "R4", 1'b0);
        burst(7,   50,  6, "R1", 1'b0);

        while (q.size() > 0) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R1: actual=timeout expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule